// File: doc/BRIEF.md
# AVI InfoFrame Builder

This block builds the 17-byte auxiliary video information packet that an HDMI transmitter sends alongside the picture. It takes the active mode (pixel clock in kHz, horizontal and vertical resolution) and a start strobe. It picks the colorimetry code from the pixel clock and the picture aspect code from the resolution ratio. It then fills in a two's-complement checksum so that the whole packet sums to zero modulo 256.

When a start is accepted, the mode inputs are sampled and the finished packet is captured in that same cycle. The bytes are then presented one per clock, each with its index and a write enable, so that a packet buffer can store them directly. A one-cycle done pulse follows the last byte. Starts that arrive while bytes are still being written are dropped.

Top module: `avi_frame_gen`

## Requirements
- R1: After reset, and until a start is accepted, byte_wr is 0, frame_done is 0, byte_idx is 0 and byte_data is 0.
- R2: Byte 0 is 0x82, byte 1 is 0x02, byte 2 is 0x0D, byte 4 is 0x12 and byte 6 is 0x88. Bytes 7 to 16 are 0x00.
- R3: Bits 7:6 of byte 5 are 01 (code 0x40, standard-definition colorimetry) when pclk_khz is at most 27000. Otherwise they are 10 (code 0x80, high-definition colorimetry).
- R4: Bits 5:0 of byte 5 are 0x18 (4:3) when h_res*100 < 156*v_res, which is the same as floor(h_res*100/v_res) < 156. Otherwise they are 0x28 (16:9). A v_res of 0 gives 16:9.
- R5: Byte 3 is (0x100 minus the 8-bit sum of the other 16 bytes) mod 256, so that the sum of all 17 bytes is 0 mod 256.
- R6: A start is accepted in a cycle when no byte is being written. In the following 17 cycles byte_wr is 1 and byte_idx steps through 0, 1, ..., 16.
- R7: frame_done is 1 for exactly one cycle, the cycle right after byte 16 is written. byte_wr is 0 in that cycle.
- R8: A start during the 17 write cycles has no effect. The index sequence and the byte values continue unchanged.
- R9: The mode inputs are sampled only in the cycle a start is accepted. Later changes do not alter the packet being written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to build and write a packet |
| pclk_khz | input | PCLK_W (20) | Pixel clock in kHz |
| h_res | input | RES_W (12) | Active pixels per line |
| v_res | input | RES_W (12) | Active lines per frame |
| byte_wr | output | 1 | Byte write enable |
| byte_idx | output | 5 | Index of the byte being written |
| byte_data | output | 8 | Byte value |
| frame_done | output | 1 | One-cycle pulse after the last byte |

## Verification
The hardest case to reach from the ports is a start that lands in the middle of a write burst with different mode inputs. The packet must still finish with the values sampled at the first start. The bench raises start and swaps all three mode inputs partway through selected bursts, then checks every remaining byte against the original mode. The aspect decision at the exact 156 ratio boundary, the 27000 kHz edge and a zero vertical resolution are driven directly. A sweep over small resolutions, crossed with a rotating set of pixel clocks, covers all four byte-5 and checksum combinations many times.

// File: rtl/avi_pkg.sv
package avi_pkg;
  localparam int unsigned FRAME_LEN = 17;
  localparam int unsigned IDX_W     = $clog2(FRAME_LEN);
  localparam int unsigned CSUM_POS  = 3;
  localparam int unsigned MODE_POS  = 5;

  typedef logic [7:0] byte_t;
  typedef logic [FRAME_LEN-1:0][7:0] frame_t;

  function automatic byte_t colorimetry_code(input logic [31:0] pclk,
                                             input logic [31:0] sd_limit);
    return (pclk <= sd_limit) ? 8'h40 : 8'h80;
  endfunction

  function automatic logic narrow_picture(input logic [31:0] xres,
                                          input logic [31:0] yres,
                                          input logic [31:0] ratio_limit);
    return (xres * 32'd100) < (ratio_limit * yres);
  endfunction

  function automatic byte_t aspect_code(input logic narrow);
    return narrow ? 8'h18 : 8'h28;
  endfunction

  function automatic byte_t fixed_byte(input int unsigned pos);
    case (pos)
      0:       return 8'h82;
      1:       return 8'h02;
      2:       return 8'h0D;
      4:       return 8'h12;
      6:       return 8'h88;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/avi_mode_classify.sv
module avi_mode_classify
  import avi_pkg::*;
#(
  parameter int unsigned PCLK_W       = 20,
  parameter int unsigned RES_W        = 12,
  parameter int unsigned SD_LIMIT_KHZ = 27000,
  parameter int unsigned RATIO_LIMIT  = 156
) (
  input  logic [PCLK_W-1:0] pclk_khz,
  input  logic [RES_W-1:0]  h_res,
  input  logic [RES_W-1:0]  v_res,
  output byte_t             mode_byte
);
  byte_t colour_part;
  byte_t shape_part;
  logic  narrow;

  always_comb begin
    colour_part = colorimetry_code(32'(pclk_khz), 32'(SD_LIMIT_KHZ));
    narrow      = narrow_picture(32'(h_res), 32'(v_res), 32'(RATIO_LIMIT));
    shape_part  = aspect_code(narrow);
    mode_byte   = colour_part | shape_part;
  end
endmodule

// File: rtl/avi_frame_assemble.sv
module avi_frame_assemble
  import avi_pkg::*;
(
  input  byte_t  mode_byte,
  output frame_t frame
);
  frame_t base;
  byte_t  partial_sum;

  for (genvar g = 0; g < FRAME_LEN; g++) begin : g_byte
    if (g == MODE_POS) begin : g_mode
      assign base[g] = mode_byte;
    end else begin : g_fixed
      assign base[g] = fixed_byte(g);
    end
  end

  always_comb begin
    partial_sum = 8'h00;
    for (int i = 0; i < FRAME_LEN; i++) begin
      if (i != CSUM_POS) partial_sum = partial_sum + base[i];
    end
    frame = base;
    frame[CSUM_POS] = 8'h00 - partial_sum;
  end
endmodule

// File: rtl/avi_byte_stream.sv
module avi_byte_stream
  import avi_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  frame_t           frame_in,
  output logic             byte_wr,
  output logic [IDX_W-1:0] byte_idx,
  output byte_t            byte_data,
  output logic             frame_done,
  output logic             accept,
  output logic             last_byte
);
  frame_t           frame_q;
  logic             busy_q;
  logic [IDX_W-1:0] idx_q;
  logic             done_q;

  assign accept    = start && !busy_q;
  assign last_byte = busy_q && (idx_q == IDX_W'(FRAME_LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      busy_q  <= 1'b0;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        frame_q <= frame_in;
        busy_q  <= 1'b1;
        idx_q   <= '0;
      end else if (last_byte) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
        done_q <= 1'b1;
      end else if (busy_q) begin
        idx_q <= idx_q + IDX_W'(1);
      end
    end
  end

  assign byte_wr    = busy_q;
  assign byte_idx   = idx_q;
  assign byte_data  = busy_q ? frame_q[idx_q] : 8'h00;
  assign frame_done = done_q;
endmodule

// File: rtl/avi_frame_gen.sv
module avi_frame_gen
  import avi_pkg::*;
#(
  parameter int unsigned PCLK_W       = 20,
  parameter int unsigned RES_W        = 12,
  parameter int unsigned SD_LIMIT_KHZ = 27000,
  parameter int unsigned RATIO_LIMIT  = 156
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PCLK_W-1:0] pclk_khz,
  input  logic [RES_W-1:0]  h_res,
  input  logic [RES_W-1:0]  v_res,
  output logic              byte_wr,
  output logic [IDX_W-1:0]  byte_idx,
  output logic [7:0]        byte_data,
  output logic              frame_done
);
  byte_t  mode_byte;
  frame_t frame_next;
  logic   frame_accept;
  logic   last_byte;

  avi_mode_classify #(
    .PCLK_W(PCLK_W), .RES_W(RES_W),
    .SD_LIMIT_KHZ(SD_LIMIT_KHZ), .RATIO_LIMIT(RATIO_LIMIT)
  ) classify_i (
    .pclk_khz(pclk_khz), .h_res(h_res), .v_res(v_res), .mode_byte(mode_byte)
  );

  avi_frame_assemble assemble_i (.mode_byte(mode_byte), .frame(frame_next));

  avi_byte_stream stream_i (
    .clk(clk), .rst_n(rst_n), .start(start), .frame_in(frame_next),
    .byte_wr(byte_wr), .byte_idx(byte_idx), .byte_data(byte_data),
    .frame_done(frame_done), .accept(frame_accept), .last_byte(last_byte)
  );
endmodule

// File: rtl/avi_frame_chk.sv
module avi_frame_chk
  import avi_pkg::*;
#(
  parameter int unsigned PCLK_W       = 20,
  parameter int unsigned SD_LIMIT_KHZ = 27000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [PCLK_W-1:0] pclk_khz,
  input logic              byte_wr,
  input logic [IDX_W-1:0]  byte_idx,
  input logic [7:0]        byte_data,
  input logic              frame_done,
  input logic              accept,
  input logic              last_byte
);
  logic [7:0] run_sum;
  logic       sd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_sum <= 8'h00;
      sd_q    <= 1'b0;
    end else begin
      if (accept) sd_q <= (32'(pclk_khz) <= 32'(SD_LIMIT_KHZ));
      if (byte_wr) run_sum <= (byte_idx == '0) ? byte_data : run_sum + byte_data;
    end
  end

  p_fixed_hdr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_wr && byte_idx == '0) |-> byte_data == 8'h82);

  p_colorimetry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_wr && byte_idx == IDX_W'(MODE_POS)) |-> byte_data[7:6] == (sd_q ? 2'b01 : 2'b10));

  p_checksum_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> run_sum == 8'h00);

  p_first_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> byte_wr && byte_idx == '0);

  p_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_wr && !last_byte) |=> byte_wr && byte_idx == IDX_W'($past(byte_idx) + 1'b1));

  p_done_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    last_byte |=> frame_done && !byte_wr);

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && byte_wr) |-> !accept);
endmodule

bind avi_frame_gen avi_frame_chk #(
  .PCLK_W(PCLK_W), .SD_LIMIT_KHZ(SD_LIMIT_KHZ)
) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .pclk_khz(pclk_khz),
  .byte_wr(byte_wr), .byte_idx(byte_idx), .byte_data(byte_data),
  .frame_done(frame_done), .accept(frame_accept), .last_byte(last_byte)
);

// File: tb/avi_frame_gen_tb_top.sv
module avi_frame_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [19:0] pclk_khz = '0;
  logic [11:0] h_res = '0;
  logic [11:0] v_res = '0;
  logic        byte_wr;
  logic [4:0]  byte_idx;
  logic [7:0]  byte_data;
  logic        frame_done;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  avi_frame_gen dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .pclk_khz(pclk_khz),
    .h_res(h_res), .v_res(v_res), .byte_wr(byte_wr), .byte_idx(byte_idx),
    .byte_data(byte_data), .frame_done(frame_done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int mode_code(input int pk, input int x, input int y);
    int c;
    c = (pk > 27000) ? 'h80 : 'h40;
    if (y != 0 && ((x * 100) / y) < 156) c += 'h18;
    else c += 'h28;
    return c;
  endfunction

  function automatic int want_byte(input int i, input int pk, input int x, input int y);
    int hdr[17];
    int s;
    foreach (hdr[k]) hdr[k] = 0;
    hdr[0] = 'h82; hdr[1] = 'h02; hdr[2] = 'h0D; hdr[4] = 'h12; hdr[6] = 'h88;
    hdr[5] = mode_code(pk, x, y);
    s = 0;
    foreach (hdr[k]) s += hdr[k];
    hdr[3] = (256 - (s % 256)) % 256;
    return hdr[i];
  endfunction

  function automatic string req_of(input int i);
    if (i == 3) return "R5";
    if (i == 5) return "R3/R4";
    return "R2";
  endfunction

  // disturb_at < 0: no mid-burst start
  task automatic run_frame(input int pk, input int x, input int y, input int disturb_at);
    int sum;
    sum = 0;
    @(negedge clk);
    pclk_khz = 20'(pk); h_res = 12'(x); v_res = 12'(y); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 17; i++) begin
      check(byte_wr === 1'b1 && byte_idx === 5'(i) && frame_done === 1'b0,
            (disturb_at >= 0) ? "R8 index" : "R6 index", int'(byte_idx), i);
      check(byte_data === 8'(want_byte(i, pk, x, y)),
            (disturb_at >= 0 && i > disturb_at) ? "R8/R9 data" : req_of(i),
            int'(byte_data), want_byte(i, pk, x, y));
      sum += int'(byte_data);
      if (i == disturb_at) begin
        start = 1'b1;
        pclk_khz = 20'(pk ^ 20'h5A5A5); h_res = 12'(y + 7); v_res = 12'(x + 3);
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    check(sum % 256 == 0, "R5 sum", sum % 256, 0);
    check(frame_done === 1'b1 && byte_wr === 1'b0, "R7 done", int'(frame_done), 1);
    @(negedge clk);
    check(frame_done === 1'b0 && byte_wr === 1'b0, "R7 single", int'(frame_done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(byte_wr === 1'b0 && frame_done === 1'b0 && byte_idx === 5'd0 && byte_data === 8'd0,
          "R1 reset", int'(byte_wr), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(byte_wr === 1'b0 && frame_done === 1'b0 && byte_idx === 5'd0,
          "R1 idle", int'(byte_wr), 0);

    // R3 boundary on pixel clock
    run_frame(27000, 640, 480, -1);
    run_frame(27001, 640, 480, -1);
    run_frame(26999, 1920, 1080, -1);
    run_frame(0, 1920, 1080, -1);
    run_frame(1048575, 4095, 4095, -1);
    // R4 boundary: 3900 vs 3900 is not below, 3800 is
    run_frame(74250, 39, 25, -1);
    run_frame(74250, 38, 25, -1);
    run_frame(74250, 100, 0, -1);
    run_frame(74250, 0, 100, -1);
    // R8 / R9: start and new inputs mid-burst
    run_frame(25175, 640, 480, 0);
    run_frame(148500, 1920, 1080, 7);
    run_frame(27000, 39, 25, 15);

    // near-exhaustive sweep of small resolutions (R3 R4 R5 R6)
    for (int x = 1; x <= 48; x++) begin
      for (int y = 1; y <= 32; y++) begin
        int pks[6];
        pks[0] = 0; pks[1] = 26999; pks[2] = 27000;
        pks[3] = 27001; pks[4] = 74250; pks[5] = 148500;
        run_frame(pks[(x + y) % 6], x, y, ((x * y) % 11 == 0) ? (x % 16) : -1);
      end
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule